// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is the timer one processor core uses for its own clock events. It has two stages. A prescaler divides the input clock into tick pulses, with a period set by a software-loaded base count. A countdown stage counts those ticks from a buffered start value. When it expires it sets a sticky interrupt flag. In repeat mode the countdown reloads after every expiry, so it keeps interrupting until software clears its start bit. In single mode it fires once and then stays quiet.

Software reaches the block through a plain 32-bit register port with separate write and read strobes. Each register sits at a fixed byte offset inside a 256-byte window. Writes to the three configuration registers each raise a sticky acknowledge flag, and software clears that flag by writing a 1 to it. The countdown buffer changes only when bit 31 of the written word is set. This lets software touch the register without altering the programmed value.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` and `bus_rdata_o` are 0.
- R2: While control bit 0 is 1, the prescaler emits one tick every (tick base + 1) clocks, where the tick base is the register at offset 0x00. While control bit 0 is 0 no ticks occur, so the countdown never expires.
- R3: A write to offset 0x08 with bit 31 set stores bits 30:0 as the countdown reload value. A write to 0x08 with bit 31 clear leaves the stored value unchanged but still raises its acknowledge flag.
- R4: While control bit 1 is 0, the countdown holds the reload value N. Once bit 1 is set, the status flag (offset 0x30 bit 0) is set on the tick that ends N ticks, where N = 0 counts as 1. The interrupt output first goes high (N·(base+1)+1) clocks after the clock edge that writes the control register.
- R5: With control bit 2 set (repeat mode), the countdown reloads on each expiry and expires again every N·(base+1) clocks.
- R6: With control bit 2 clear, the countdown expires once and then stays quiet until control bit 1 is cleared and set again.
- R7: Writing 1 to status bit 0 clears it, but an expiry in the same cycle takes priority. `irq_o` equals (status AND enable bit 0 at 0x34), registered one clock later.
- R8: Offset 0x40 holds acknowledge flags. Bit 0 is set by a write to 0x00, bit 1 by a write to 0x08, and bit 3 by a write to 0x20. Writing 1 to a flag clears it.
- R9: Writes to any offset other than 0x00, 0x08, 0x20, 0x30, 0x34 and 0x40 change nothing and raise no flag. Reads of those other offsets return 0.
- R10: Reads one clock after `bus_ren_i` return the tick base, the reload value, control bits 2:0, status, enable and acknowledge flags at their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wen_i | input | 1 | Write strobe, one clock per write |
| bus_ren_i | input | 1 | Read strobe; data is valid on the next clock |
| bus_addr_i | input | 8 | Byte offset within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, held between reads |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume the write and read strobes are never both high in one clock. They also assume a write strobe lasts exactly one clock per access, so the acknowledge and no-effect checks see one write at a time. The stimulus drives the bus one access at a time and holds each strobe for a single cycle. It lowers the strobes on the falling edge, so the block's inputs never violate these assumptions.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned OFFS_W = 8;

  localparam logic [OFFS_W-1:0] OFS_TICK_BASE = 8'h00;
  localparam logic [OFFS_W-1:0] OFS_RELOAD    = 8'h08;
  localparam logic [OFFS_W-1:0] OFS_CONTROL   = 8'h20;
  localparam logic [OFFS_W-1:0] OFS_STATUS    = 8'h30;
  localparam logic [OFFS_W-1:0] OFS_ENABLE    = 8'h34;
  localparam logic [OFFS_W-1:0] OFS_ACK       = 8'h40;

  localparam int unsigned CTL_TICK_RUN = 0;
  localparam int unsigned CTL_CNT_RUN  = 1;
  localparam int unsigned CTL_REPEAT   = 2;

  localparam int unsigned ACK_TICK   = 0;
  localparam int unsigned ACK_RELOAD = 1;
  localparam int unsigned ACK_CTL    = 3;
  localparam int unsigned ACK_W      = 4;

  localparam int unsigned RELOAD_COMMIT_BIT = 31;
endpackage

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned CNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wen_i,
  input  logic              ren_i,
  input  logic [OFFS_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              expire_i,
  output logic [TICK_W-1:0] tick_base_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [2:0]        ctl_o,
  output logic              irq_o
);
  logic [TICK_W-1:0] tick_base_q;
  logic [CNT_W-1:0]  reload_q;
  logic [2:0]        ctl_q;
  logic              stat_q;
  logic              ien_q;
  logic [ACK_W-1:0]  ack_q, ack_nxt;
  logic              irq_q;
  logic [BUS_W-1:0]  rdata_q, rd_mux;

  logic hit_tb, hit_rl, hit_ctl, hit_st, hit_en, hit_ack, any_hit;
  assign hit_tb  = (addr_i == OFS_TICK_BASE);
  assign hit_rl  = (addr_i == OFS_RELOAD);
  assign hit_ctl = (addr_i == OFS_CONTROL);
  assign hit_st  = (addr_i == OFS_STATUS);
  assign hit_en  = (addr_i == OFS_ENABLE);
  assign hit_ack = (addr_i == OFS_ACK);
  assign any_hit = hit_tb | hit_rl | hit_ctl | hit_st | hit_en | hit_ack;

  always_comb begin
    ack_nxt = ack_q;
    if (wen_i && hit_ack) ack_nxt = ack_nxt & ~wdata_i[ACK_W-1:0];
    if (wen_i && hit_tb)  ack_nxt[ACK_TICK]   = 1'b1;
    if (wen_i && hit_rl)  ack_nxt[ACK_RELOAD] = 1'b1;
    if (wen_i && hit_ctl) ack_nxt[ACK_CTL]    = 1'b1;
    ack_nxt[2] = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_tb)  rd_mux = BUS_W'(tick_base_q);
    if (hit_rl)  rd_mux = BUS_W'(reload_q);
    if (hit_ctl) rd_mux = BUS_W'(ctl_q);
    if (hit_st)  rd_mux = BUS_W'(stat_q);
    if (hit_en)  rd_mux = BUS_W'(ien_q);
    if (hit_ack) rd_mux = BUS_W'(ack_q);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tick_base_q <= '0;
      reload_q    <= '0;
      ctl_q       <= '0;
      stat_q      <= 1'b0;
      ien_q       <= 1'b0;
      ack_q       <= '0;
      irq_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (wen_i && hit_tb) tick_base_q <= wdata_i[TICK_W-1:0];
      if (wen_i && hit_rl && wdata_i[RELOAD_COMMIT_BIT]) reload_q <= wdata_i[CNT_W-1:0];
      if (wen_i && hit_ctl) ctl_q <= wdata_i[2:0];
      if (wen_i && hit_en)  ien_q <= wdata_i[0];
      if (expire_i) stat_q <= 1'b1;
      else if (wen_i && hit_st && wdata_i[0]) stat_q <= 1'b0;
      ack_q <= ack_nxt;
      irq_q <= stat_q & ien_q;
      if (ren_i) rdata_q <= rd_mux;
    end
  end

  assign tick_base_o = tick_base_q;
  assign reload_o    = reload_q;
  assign ctl_o       = ctl_q;
  assign irq_o       = irq_q;
  assign rdata_o     = rdata_q;

  assert_ack_ctrl_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (wen_i && hit_ctl) |=> ack_q[ACK_CTL]);
  assert_undef_ignored_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (wen_i && !any_hit) |=> ($stable(ctl_q) && $stable(tick_base_q) &&
                             $stable(reload_q) && $stable(ien_q) && $stable(ack_q)));
  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ien_q) |=> !irq_q);
endmodule

// File: rtl/ctt_prescale.sv
module ctt_prescale #(
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic [TICK_W-1:0] tick_base_i,
  output logic              tick_o
);
  logic [TICK_W-1:0] div_q;
  logic              wrap;

  assign wrap   = (div_q >= tick_base_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) div_q <= '0;
    else if (wrap)       div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && tick_base_i != '0) |=> (!tick_o || tick_base_i == '0));
endmodule

// File: rtl/ctt_countdown.sv
module ctt_countdown #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             repeat_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last;

  assign last     = (cnt_q <= CNT_W'(1));
  assign expire_o = start_i && tick_i && !done_q && last;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!start_i) begin
      cnt_q  <= reload_i;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (last) begin
        if (repeat_i) cnt_q <= reload_i;
        else          done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_hold_no_tick_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !tick_i) |=> $stable(cnt_q));
  assert_single_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire_o && !repeat_i) |=> !expire_o);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter int unsigned CNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_wen_i,
  input  logic              bus_ren_i,
  input  logic [OFFS_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [TICK_W-1:0] tick_base;
  logic [CNT_W-1:0]  reload;
  logic [2:0]        ctl;
  logic              tick;
  logic              expire;

  ctt_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wen_i       (bus_wen_i),
    .ren_i       (bus_ren_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .expire_i    (expire),
    .tick_base_o (tick_base),
    .reload_o    (reload),
    .ctl_o       (ctl),
    .irq_o       (irq_o)
  );

  ctt_prescale #(.TICK_W(TICK_W)) u_pre (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (ctl[CTL_TICK_RUN]),
    .tick_base_i (tick_base),
    .tick_o      (tick)
  );

  ctt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (ctl[CTL_CNT_RUN]),
    .repeat_i (ctl[CTL_REPEAT]),
    .tick_i   (tick),
    .reload_i (reload),
    .expire_o (expire)
  );

  assert_no_tick_stopped_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctl[CTL_TICK_RUN]) |-> !expire);
endmodule

// File: tb/tb_core_tick_timer.sv
`timescale 1ns/1ps
module tb_core_tick_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        wen, ren;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  int          t0;
  logic [31:0] rv;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_tick_timer dut (
    .clk_i(clk), .rst_i(rst), .bus_wen_i(wen), .bus_ren_i(ren),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  localparam int NV = 5;
  localparam int VEC_BASE [NV] = '{0, 0, 3, 2, 4};
  localparam int VEC_N    [NV] = '{1, 5, 2, 0, 3};
  localparam int VEC_REP  [NV] = '{0, 0, 0, 0, 1};
  localparam int VEC_D    [NV] = '{2, 6, 9, 4, 16};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wen = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); ren = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); ren = 1'b0; d = rdata;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; wen = 1'b0; ren = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk(irq, 0, "R1 irq");
    chk(rdata, 0, "R1 rdata");
    rd(8'h00, rv); chk(rv, 0, "R1 tick base");
    rd(8'h08, rv); chk(rv, 0, "R1 reload");
    rd(8'h20, rv); chk(rv, 0, "R1 control");
    rd(8'h30, rv); chk(rv, 0, "R1 status");
    rd(8'h34, rv); chk(rv, 0, "R1 enable");
    rd(8'h40, rv); chk(rv, 0, "R1 ack");

    // R8 acknowledge flags
    wr(8'h00, 32'd5);          rd(8'h40, rv); chk(rv, 32'h1, "R8 tick ack");
    wr(8'h08, 32'h8000_0007);  rd(8'h40, rv); chk(rv, 32'h3, "R8 reload ack");
    wr(8'h20, 32'h0);          rd(8'h40, rv); chk(rv, 32'hB, "R8 control ack");
    wr(8'h40, 32'h3);          rd(8'h40, rv); chk(rv, 32'h8, "R8 partial clear");
    wr(8'h40, 32'h8);          rd(8'h40, rv); chk(rv, 32'h0, "R8 full clear");

    // R10 readback, R3 commit bit
    rd(8'h00, rv); chk(rv, 32'd5, "R10 tick base readback");
    rd(8'h08, rv); chk(rv, 32'd7, "R10 reload readback");
    wr(8'h08, 32'h0000_0055);
    rd(8'h08, rv); chk(rv, 32'd7, "R3 reload kept without bit 31");
    rd(8'h40, rv); chk(rv, 32'h2, "R3 ack still raised");
    wr(8'h34, 32'h1); rd(8'h34, rv); chk(rv, 32'h1, "R10 enable readback");
    wr(8'h20, 32'h4); rd(8'h20, rv); chk(rv, 32'h4, "R10 control readback");
    wr(8'h20, 32'h0);
    wr(8'h40, 32'hF);

    // R9 undefined offsets
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, rv); chk(rv, 0, "R9 no ack from undefined write");
    rd(8'h10, rv); chk(rv, 0, "R9 undefined read zero");
    rd(8'h04, rv); chk(rv, 0, "R9 undefined read zero");
    rd(8'h20, rv); chk(rv, 0, "R9 control untouched");
    rd(8'h00, rv); chk(rv, 32'd5, "R9 tick base untouched");
    chk(irq, 0, "R9 irq quiet");

    // R2/R4 vector table: first interrupt timing
    for (int i = 0; i < NV; i++) begin
      wr(8'h20, 32'h0);
      wr(8'h00, 32'(VEC_BASE[i]));
      wr(8'h08, 32'h8000_0000 | 32'(VEC_N[i]));
      wr(8'h30, 32'h1);
      wr(8'h34, 32'h1);
      wr(8'h20, 32'h3 | (32'(VEC_REP[i]) << 2));
      t0 = cyc;
      wait_to(t0 + VEC_D[i] - 1); chk(irq, 0, "R4 before expiry");
      wait_to(t0 + VEC_D[i]);     chk(irq, 1, "R4 R2 at expiry");
    end

    // R5 repeat mode: base 1, count 3 -> period 6
    wr(8'h20, 32'h0);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h8000_0003);
    wr(8'h30, 32'h1);
    wr(8'h20, 32'h7);
    t0 = cyc;
    wait_to(t0 + 6);  chk(irq, 0, "R5 first pre");
    wait_to(t0 + 7);  chk(irq, 1, "R5 first");
    wr(8'h30, 32'h1);
    wait_to(t0 + 12); chk(irq, 0, "R5 second pre");
    wait_to(t0 + 13); chk(irq, 1, "R5 second");
    wr(8'h30, 32'h1);
    wait_to(t0 + 18); chk(irq, 0, "R5 third pre");
    wait_to(t0 + 19); chk(irq, 1, "R5 third");

    // R6 single mode
    wr(8'h20, 32'h0);
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h8000_0002);
    wr(8'h30, 32'h1);
    wr(8'h20, 32'h3);
    t0 = cyc;
    wait_to(t0 + 2);  chk(irq, 0, "R6 pre");
    wait_to(t0 + 3);  chk(irq, 1, "R6 fire");
    wr(8'h30, 32'h1);
    wait_to(t0 + 30); chk(irq, 0, "R6 stays quiet");
    rd(8'h30, rv); chk(rv, 0, "R6 no second expiry");
    wr(8'h20, 32'h0);
    wr(8'h20, 32'h3);
    t0 = cyc;
    wait_to(t0 + 3);  chk(irq, 1, "R6 restart fires");

    // R7 set wins over clear, enable gating
    wr(8'h20, 32'h0);
    wr(8'h08, 32'h8000_0001);
    wr(8'h20, 32'h7);
    wr(8'h30, 32'h1);
    rd(8'h30, rv); chk(rv, 1, "R7 expiry beats clear");
    wr(8'h34, 32'h0);
    repeat (3) @(negedge clk);
    chk(irq, 0, "R7 gated by enable");
    rd(8'h30, rv); chk(rv, 1, "R7 status still set");
    wr(8'h34, 32'h1);
    @(negedge clk);
    chk(irq, 1, "R7 enable releases irq");

    // R2 prescaler stopped: no ticks, no expiry
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h20, 32'h2);
    repeat (20) @(negedge clk);
    chk(irq, 0, "R2 no irq without tick run");
    rd(8'h30, rv); chk(rv, 0, "R2 no expiry without tick run");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule